// File: doc/BRIEF.md
# Remote GPIO Mirror with PWM Output

This block is the general-purpose I/O engine at the receiving end of a wireless control link. It watches a small group of digital input pins. While the link is up, every change on those pins becomes a change event that carries a snapshot of all inputs. The event waits in a handshake register until the transport side acknowledges it. The same pins can also pull the device out of power-down: while the power-down flag is set, a change on an input whose wake-mask bit is set raises a wake request.

The output pins follow an output register that the controlling side writes remotely. Because they are plain levels, they can drive indicators, enables or extra SPI slave selects. One output bit (bit 3 by default) can be switched over to a pulse-width modulated waveform. That waveform has a 256-tick period, paced by a clock-enable input. Its 8-bit duty register is also written remotely, and a new duty value takes effect at the next period boundary.

The change-report logic is a two-state machine: `EV_IDLE` and `EV_HOLD`. Its transitions are:
- **report**: `EV_IDLE` to `EV_HOLD`, on a change while the link is up.
- **merge**: `EV_HOLD` to `EV_HOLD`, on a change, which reloads the snapshot.
- **consume**: `EV_HOLD` to `EV_IDLE`, on an acknowledge with no new change.
- **drop**: `EV_HOLD` to `EV_IDLE`, when the link goes down.

The wake logic has the states `WK_IDLE` and `WK_FIRED`. Its transitions are:
- **fire**: `WK_IDLE` to `WK_FIRED`, on a masked change during power-down.
- **release**: `WK_FIRED` to `WK_IDLE`, when power-down clears.

Top module: `rgpio_mirror`

## Requirements
- R1: After reset, pin_out is 0, evt_valid is 0 and wake_req is 0. The inputs are taken to be low as the reset baseline.
- R2: Each input passes through a two-flop synchronizer. A change held on pin_in from just after one rising edge shows on evt_valid after the third rising edge, and not after the second.
- R3: While link_up is 1, any change of pin_in raises evt_valid. evt_data then holds the synchronized inputs, with bit i taken from pin_in[i].
- R4: A raised event keeps evt_valid at 1 and evt_data stable until evt_ack is 1 at a rising edge. With no new change in that cycle, evt_valid is 0 after that edge.
- R5: Changes that arrive before the acknowledge are merged. There is still one event, and its evt_data is the latest snapshot.
- R6: While link_up is 0, no event is raised and a pending event is dropped at the next edge. Input changes made while the link was down produce no event when the link comes back up.
- R7: A pulse on out_wr loads out_wdata into the output register at the next edge. Every pin_out bit that is not carrying PWM then equals the written bit.
- R8: A pulse on mode_wr loads the PWM enable (mode_pwm_en) and the 4-bit wake mask (mode_wake_mask, bit i for input i). While PWM is enabled, pin_out[3] carries the waveform and output-register bit 3 has no effect.
- R9: The PWM period is 256 cycles in which tick_en is 1. pin_out[3] is high for exactly duty of them, so a duty of 0 gives a constant low. A value written by duty_wr takes effect within 256 ticks, at a period boundary.
- R10: While pdown is 1, a change on a masked input sets wake_req after the third rising edge. Changes on unmasked inputs are ignored. wake_req stays 1 until pdown is 0 at an edge and then clears. While pdown is 0, no wake request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 4 | Monitored input pins (asynchronous) |
| pin_out | output | 4 | Driven output pins |
| out_wr | input | 1 | Write strobe for the output register |
| out_wdata | input | 4 | Output register write value |
| duty_wr | input | 1 | Write strobe for the PWM duty register |
| duty_wdata | input | 8 | PWM duty value (high ticks per 256) |
| mode_wr | input | 1 | Write strobe for PWM enable and wake mask |
| mode_pwm_en | input | 1 | 1 selects PWM on output bit 3 |
| mode_wake_mask | input | 4 | Per-input wake enable |
| tick_en | input | 1 | PWM clock enable |
| link_up | input | 1 | Link established flag |
| pdown | input | 1 | Power-down flag |
| evt_valid | output | 1 | Change event pending |
| evt_data | output | 4 | Input snapshot of the pending event |
| evt_ack | input | 1 | Event consumed by the transport |
| wake_req | output | 1 | Wake request from power-down |

## Verification
If the report machine is stuck in the wrong state, evt_valid shows it. It either fails to rise on the third edge after an input change, or it stays high past an acknowledge. A stale snapshot shows as evt_data differing from the pins within the same cycle that evt_valid is sampled. The bench steps through every ordered pair of 4-bit input values. A wrong PWM counter or duty shadow shows within one 256-tick period as a wrong count of high cycles on output bit 3. A wake machine that fails to release shows as wake_req still high one cycle after power-down clears.

// File: rtl/rgpio_pkg.sv
package rgpio_pkg;
    typedef enum logic {
        EV_IDLE = 1'b0,
        EV_HOLD = 1'b1
    } evt_state_t;

    typedef enum logic {
        WK_IDLE  = 1'b0,
        WK_FIRED = 1'b1
    } wake_state_t;
endpackage

// File: rtl/rgpio_sync.sv
module rgpio_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync,
    output logic [W-1:0] q_chg
);
    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
            prev_q <= '0;
        end else begin
            stg[0] <= d_async;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
            prev_q <= stg[STAGES-1];
        end
    end

    assign q_sync = stg[STAGES-1];
    assign q_chg  = stg[STAGES-1] ^ prev_q;
endmodule

// File: rtl/rgpio_evt.sv
module rgpio_evt
    import rgpio_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         link_up,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] chg,
    input  logic         ack,
    output logic         valid,
    output logic [W-1:0] data
);
    evt_state_t   st_q, st_d;
    logic         snap_ld;
    logic [W-1:0] snap_q;
    logic         any_chg;

    assign any_chg = |chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= EV_IDLE;
            snap_q <= '0;
        end else begin
            st_q <= st_d;
            if (snap_ld) snap_q <= cur;
        end
    end

    always_comb begin
        st_d    = st_q;
        snap_ld = 1'b0;
        unique case (st_q)
            EV_IDLE: begin
                if (link_up && any_chg) begin        // report
                    st_d    = EV_HOLD;
                    snap_ld = 1'b1;
                end
            end
            EV_HOLD: begin
                if (!link_up) begin                  // drop
                    st_d = EV_IDLE;
                end else if (any_chg) begin          // merge
                    st_d    = EV_HOLD;
                    snap_ld = 1'b1;
                end else if (ack) begin              // consume
                    st_d = EV_IDLE;
                end
            end
            default: st_d = EV_IDLE;
        endcase
    end

    always_comb begin
        valid = (st_q == EV_HOLD);
        data  = snap_q;
    end
endmodule

// File: rtl/rgpio_wake.sv
module rgpio_wake
    import rgpio_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pdown,
    input  logic [W-1:0] chg,
    input  logic [W-1:0] mask,
    output logic         wake
);
    wake_state_t st_q, st_d;
    logic        hit;

    assign hit = |(chg & mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WK_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WK_IDLE:  if (pdown && hit) st_d = WK_FIRED;   // fire
            WK_FIRED: if (!pdown)       st_d = WK_IDLE;    // release
            default:  st_d = WK_IDLE;
        endcase
    end

    always_comb begin
        wake = (st_q == WK_FIRED);
    end
endmodule

// File: rtl/rgpio_pwm.sv
module rgpio_pwm #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enable,
    input  logic [DUTY_W-1:0] duty_reg,
    output logic [DUTY_W-1:0] duty_live,
    output logic              wave
);
    localparam logic [DUTY_W-1:0] CNT_LAST = {DUTY_W{1'b1}};

    logic [DUTY_W-1:0] cnt_q;
    logic [DUTY_W-1:0] act_q;
    logic              boundary;

    assign boundary = tick && (cnt_q == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= '0;
        end else begin
            if (tick) cnt_q <= cnt_q + 1'b1;
            if (!enable || boundary) act_q <= duty_reg;
        end
    end

    assign duty_live = act_q;
    assign wave      = (cnt_q < act_q);
endmodule

// File: rtl/rgpio_mirror.sv
module rgpio_mirror #(
    parameter int N_IO        = 4,
    parameter int DUTY_W      = 8,
    parameter int PWM_BIT     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IO-1:0]   pin_in,
    output logic [N_IO-1:0]   pin_out,
    input  logic              out_wr,
    input  logic [N_IO-1:0]   out_wdata,
    input  logic              duty_wr,
    input  logic [DUTY_W-1:0] duty_wdata,
    input  logic              mode_wr,
    input  logic              mode_pwm_en,
    input  logic [N_IO-1:0]   mode_wake_mask,
    input  logic              tick_en,
    input  logic              link_up,
    input  logic              pdown,
    output logic              evt_valid,
    output logic [N_IO-1:0]   evt_data,
    input  logic              evt_ack,
    output logic              wake_req
);
    logic [N_IO-1:0]   in_sync;
    logic [N_IO-1:0]   in_chg;
    logic [N_IO-1:0]   out_q;
    logic [N_IO-1:0]   wmask_q;
    logic [DUTY_W-1:0] duty_q;
    logic [DUTY_W-1:0] duty_act;
    logic              pwm_en;
    logic              pwm_wave;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            wmask_q <= '0;
            duty_q  <= '0;
            pwm_en  <= 1'b0;
        end else begin
            if (out_wr)  out_q  <= out_wdata;
            if (duty_wr) duty_q <= duty_wdata;
            if (mode_wr) begin
                pwm_en  <= mode_pwm_en;
                wmask_q <= mode_wake_mask;
            end
        end
    end

    rgpio_sync #(.W(N_IO), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (in_sync),
        .q_chg   (in_chg)
    );

    rgpio_evt #(.W(N_IO)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_up (link_up),
        .cur     (in_sync),
        .chg     (in_chg),
        .ack     (evt_ack),
        .valid   (evt_valid),
        .data    (evt_data)
    );

    rgpio_wake #(.W(N_IO)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .pdown (pdown),
        .chg   (in_chg),
        .mask  (wmask_q),
        .wake  (wake_req)
    );

    rgpio_pwm #(.DUTY_W(DUTY_W)) u_pwm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_en),
        .enable    (pwm_en),
        .duty_reg  (duty_q),
        .duty_live (duty_act),
        .wave      (pwm_wave)
    );

    for (genvar i = 0; i < N_IO; i++) begin : g_out
        if (i == PWM_BIT) begin : g_pwm
            assign pin_out[i] = pwm_en ? pwm_wave : out_q[i];
        end else begin : g_lvl
            assign pin_out[i] = out_q[i];
        end
    end
endmodule

// File: rtl/rgpio_mirror_chk.sv
module rgpio_mirror_chk #(
    parameter int N_IO    = 4,
    parameter int DUTY_W  = 8,
    parameter int PWM_BIT = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_wr,
    input logic [N_IO-1:0]   out_wdata,
    input logic [N_IO-1:0]   pin_out,
    input logic              link_up,
    input logic              evt_valid,
    input logic              evt_ack,
    input logic              pdown,
    input logic              wake_req,
    input logic              pwm_en,
    input logic [DUTY_W-1:0] duty_act
);
    localparam logic [N_IO-1:0] LVL_MASK = ~(N_IO'(1) << PWM_BIT);

    // R4
    evt_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ack && link_up) |=> evt_valid);

    // R6
    no_evt_linkdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> !evt_valid);

    // R7
    out_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |=> (((pin_out ^ $past(out_wdata)) & LVL_MASK) == '0));

    // R9
    duty_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && duty_act == '0) |-> !pin_out[PWM_BIT]);

    // R10
    wake_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pdown |=> !wake_req);
endmodule

bind rgpio_mirror rgpio_mirror_chk #(
    .N_IO(N_IO), .DUTY_W(DUTY_W), .PWM_BIT(PWM_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_wr    (out_wr),
    .out_wdata (out_wdata),
    .pin_out   (pin_out),
    .link_up   (link_up),
    .evt_valid (evt_valid),
    .evt_ack   (evt_ack),
    .pdown     (pdown),
    .wake_req  (wake_req),
    .pwm_en    (pwm_en),
    .duty_act  (duty_act)
);

// File: tb/rgpio_mirror_bench.sv
module rgpio_mirror_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin_in = '0;
    logic [3:0] pin_out;
    logic       out_wr = 1'b0;
    logic [3:0] out_wdata = '0;
    logic       duty_wr = 1'b0;
    logic [7:0] duty_wdata = '0;
    logic       mode_wr = 1'b0;
    logic       mode_pwm_en = 1'b0;
    logic [3:0] mode_wake_mask = '0;
    logic       tick_en = 1'b1;
    logic       link_up = 1'b0;
    logic       pdown = 1'b0;
    logic       evt_valid;
    logic [3:0] evt_data;
    logic       evt_ack = 1'b0;
    logic       wake_req;

    logic       tick_half = 1'b0;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    rgpio_mirror u_rgpio_mirror (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out),
        .out_wr(out_wr), .out_wdata(out_wdata), .duty_wr(duty_wr),
        .duty_wdata(duty_wdata), .mode_wr(mode_wr), .mode_pwm_en(mode_pwm_en),
        .mode_wake_mask(mode_wake_mask), .tick_en(tick_en), .link_up(link_up),
        .pdown(pdown), .evt_valid(evt_valid), .evt_data(evt_data),
        .evt_ack(evt_ack), .wake_req(wake_req)
    );

    initial forever begin
        @(negedge clk);
        tick_en = tick_half ? ~tick_en : 1'b1;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack_evt();
        evt_ack = 1'b1;
        cyc(1);
        evt_ack = 1'b0;
    endtask

    task automatic wr_out(input logic [3:0] v);
        out_wdata = v; out_wr = 1'b1; cyc(1); out_wr = 1'b0;
    endtask

    task automatic wr_duty(input logic [7:0] v);
        duty_wdata = v; duty_wr = 1'b1; cyc(1); duty_wr = 1'b0;
    endtask

    task automatic wr_mode(input logic en, input logic [3:0] m);
        mode_pwm_en = en; mode_wake_mask = m; mode_wr = 1'b1; cyc(1); mode_wr = 1'b0;
    endtask

    task automatic count_high(input int span, output int hi);
        hi = 0;
        for (int k = 0; k < span; k++) begin
            @(negedge clk);
            if (pin_out[3]) hi++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int hi;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        check("R1 pin_out", pin_out, 0);
        check("R1 evt_valid", evt_valid, 0);
        check("R1 wake_req", wake_req, 0);

        link_up = 1'b1;
        cyc(2);
        // R2 latency: not yet after two edges, visible after three
        pin_in = 4'h9;
        cyc(2);
        check("R2 early", evt_valid, 0);
        cyc(1);
        check("R2 third edge", evt_valid, 1);
        check("R3 data", evt_data, 9);
        cyc(3);
        check("R4 held", evt_valid, 1);
        ack_evt();
        check("R4 cleared", evt_valid, 0);

        // R3/R4 sweep over all ordered pairs
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                pin_in = 4'(a);
                cyc(3);
                if (evt_valid) ack_evt();
                pin_in = 4'(b);
                cyc(3);
                check("R3 pair valid", evt_valid, (a != b) ? 1 : 0);
                if (a != b) begin
                    check("R3 pair data", evt_data, b);
                    ack_evt();
                    check("R4 pair consume", evt_valid, 0);
                end
            end
        end

        // R5 merge
        pin_in = 4'h0; cyc(3); if (evt_valid) ack_evt();
        pin_in = 4'h1; cyc(3);
        pin_in = 4'h3; cyc(3);
        check("R5 merged valid", evt_valid, 1);
        check("R5 merged data", evt_data, 3);
        ack_evt();
        check("R5 single event", evt_valid, 0);

        // R6 link down
        link_up = 1'b0;
        pin_in = 4'h5; cyc(4);
        check("R6 no evt down", evt_valid, 0);
        link_up = 1'b1; cyc(4);
        check("R6 no evt on up", evt_valid, 0);
        pin_in = 4'hA; cyc(3);
        check("R6 pending", evt_valid, 1);
        link_up = 1'b0; cyc(1);
        check("R6 dropped", evt_valid, 0);
        link_up = 1'b1; cyc(2);

        // R7 output register sweep
        for (int v = 0; v < 16; v++) begin
            wr_out(4'(v));
            check("R7 out level", pin_out, v);
        end

        // R8 PWM select, bit 3 of the register ignored
        wr_out(4'h5);
        wr_duty(8'd0);
        wr_mode(1'b1, 4'h0);
        cyc(260);
        wr_out(4'hF);
        check("R8 bit3 ignored", pin_out, 7);
        wr_out(4'h5);
        check("R8 low bits", pin_out[2:0], 5);

        // R9 duty sweep, tick every cycle
        for (int d = 0; d < 256; d += 3) begin
            wr_duty(8'(d));
            cyc(256);
            count_high(256, hi);
            check("R9 duty count", hi, d);
        end
        wr_duty(8'd255); cyc(256); count_high(256, hi);
        check("R9 duty max", hi, 255);
        wr_duty(8'd0); cyc(256); count_high(512, hi);
        check("R9 duty zero", hi, 0);

        // R9 with tick every other cycle
        tick_half = 1'b1;
        wr_duty(8'd100); cyc(520); count_high(512, hi);
        check("R9 half tick", hi, 200);
        tick_half = 1'b0;
        wr_mode(1'b0, 4'h0);
        wr_out(4'h8);
        check("R8 pwm off level", pin_out, 8);

        // R10 wake
        link_up = 1'b0;
        pin_in = 4'h0; cyc(4);
        wr_mode(1'b0, 4'h1);
        pdown = 1'b1; cyc(1);
        pin_in = 4'h2; cyc(5);
        check("R10 unmasked", wake_req, 0);
        pin_in = 4'h3; cyc(2);
        check("R10 early", wake_req, 0);
        cyc(1);
        check("R10 fired", wake_req, 1);
        pin_in = 4'h0; cyc(4);
        check("R10 holds", wake_req, 1);
        pdown = 1'b0; cyc(1);
        check("R10 release", wake_req, 0);
        pin_in = 4'h1; cyc(5);
        check("R10 awake ignored", wake_req, 0);

        finish_run();
    end
endmodule